// File: doc/BRIEF.md
# I2C In-Band Command Sequencer

This block sits between a queue of transfer words and a byte-level I2C bit engine. Software or an upstream master pushes 10-bit words into a small transmit queue. Each word's low byte is payload. Two extra marker bits say whether the byte opens a (repeated) START or closes the message with a STOP. The sequencer pops the words and turns them into single byte operations for the bit engine: START with an address byte, data write, data read, and STOP. A complete multi-message transfer, including reads and repeated starts, can therefore be queued with no control writes in between.

A read is requested by an address byte whose bit 0 is 1. The word after it carries the number of bytes to receive, and may carry the STOP marker. Received bytes appear on a one-cycle strobe. If the target NACKs an address or data byte, the sequencer closes the bus, discards the rest of that message and flags an error. The block also reports queue occupancy and raw interrupt sources.

Top module: `i2c_cmd_seq`

## Requirements
- R1: The queue holds 16 words. `fifo_level` shows the word count minus one, and shows 0 when the queue is empty. `fifo_full` is high at 16 words. A push while full is dropped.
- R2: A word with bit 8 set makes the block issue op START (code 0) with the word's bits [7:0] as `eng_byte`. This also claims the bus, so `bus_busy` goes to 1.
- R3: While the bus is held, a word with bits 9:8 equal to 00 is issued as op WRITE (code 1) carrying its low byte.
- R4: A word with bit 9 set is followed by op STOP (code 3) once its own byte completes without NACK. A START word with both markers set produces START followed directly by STOP.
- R5: After a START whose address byte has bit 0 = 1, the next word's low byte N gives the number of op READ (code 2) operations. `eng_last` is 1 only on the N-th read, which the engine NACKs. Every completed read is presented once on `rx_valid`/`rx_data`.
- R6: If the length word has bit 9 set, STOP follows the last read. Otherwise the bus stays held and the next START is a repeated start.
- R7: When `eng_nack` is reported on a START or WRITE, the block issues STOP and discards queued words up to, but not including, the next word with bit 8 set. It also sets `irq_src[1]`.
- R8: A word without bit 8 that arrives while the bus is idle is dropped with no bus operation, and it sets `irq_src[1]`.
- R9: `irq_src[2]` is high when the queue is empty. `irq_src[7]` is high when the queue holds at most 8 words.
- R10: `irq_src[4]` is set when a STOP completes and the bus goes idle. `irq_src[1]` and `irq_src[4]` stay set until the matching bit of `irq_clr` is pulsed. All other bits of `irq_src` read 0.
- R11: `eng_req` stays high with stable `eng_op`, `eng_byte` and `eng_last` until the engine pulses `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_word` into the queue |
| wr_word | input | 10 | Bit 9 = STOP marker, bit 8 = START marker, [7:0] = payload |
| fifo_level | output | 4 | Zero-based occupancy |
| fifo_full | output | 1 | Queue holds 16 words |
| eng_req | output | 1 | Operation request to the bit engine |
| eng_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| eng_byte | output | 8 | Address or data byte for START/WRITE |
| eng_last | output | 1 | Read byte is the last; engine answers NACK |
| eng_done | input | 1 | One-cycle completion of the current operation |
| eng_nack | input | 1 | Target NACKed (valid with `eng_done`) |
| eng_rdata | input | 8 | Received byte (valid with `eng_done` of a READ) |
| rx_valid | output | 1 | One-cycle strobe of a received byte |
| rx_data | output | 8 | Received byte |
| bus_busy | output | 1 | Bus claimed between START and STOP |
| irq_src | output | 8 | Raw interrupt sources (bits 1, 2, 4, 7) |
| irq_clr | input | 8 | Write-one pulse clearing sticky sources |

## Verification
A wrong sequencer state shows up as a wrong or missing operation code on the engine port, typically at the very next request. This could be a missing STOP, a READ where a START belongs, or a flushed word that is sent anyway. The bench therefore logs every engine request and compares the whole operation list, bytes and last-byte flags, against a list built from the pushed words. Queue counter errors show on `fifo_level` and the level-type interrupt bits in the cycle after each push. Sticky-flag errors show after each clear pulse.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int WORD_W    = 10;
  localparam int START_BIT = 8;
  localparam int STOP_BIT  = 9;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_LEN, S_READ, S_FLUSH, S_STOP
  } seq_state_e;
endpackage

// File: rtl/seqq_fifo.sv
module seqq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_word,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] count_n;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp];

  always_comb begin
    wp_n    = wp;
    rp_n    = rp;
    count_n = count;
    if (push_ok) wp_n = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
    if (pop_ok)  rp_n = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
    if (push_ok && !pop_ok)      count_n = count + 1'b1;
    else if (pop_ok && !push_ok) count_n = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp_n;
      rp    <= rp_n;
      count <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_word;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count)); // R1
endmodule

// File: rtl/seqq_ctrl.sv
module seqq_ctrl
  import i2cq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] head,
  input  logic              empty,
  output logic              pop,
  output logic              eng_req,
  output bus_op_e           eng_op,
  output logic [7:0]        eng_byte,
  output logic              eng_last,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [7:0]        eng_rdata,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              bus_busy,
  output logic              set_err,
  output logic              set_bnb
);
  seq_state_e state, state_n;
  logic       req_n, last_n, busy_n, rxv_n, stop_q, stop_n, rd_q, rd_n;
  bus_op_e    op_n;
  logic [7:0] byte_n, rxd_n, left_q, left_n;

  always_comb begin
    state_n = state;
    req_n   = eng_req;
    op_n    = eng_op;
    byte_n  = eng_byte;
    last_n  = eng_last;
    busy_n  = bus_busy;
    stop_n  = stop_q;
    rd_n    = rd_q;
    left_n  = left_q;
    rxv_n   = 1'b0;
    rxd_n   = rx_data;
    pop     = 1'b0;
    set_err = 1'b0;
    set_bnb = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (!empty) begin
          pop = 1'b1;
          if (head[START_BIT]) begin
            req_n   = 1'b1;
            op_n    = OP_START;
            byte_n  = head[7:0];
            last_n  = 1'b0;
            rd_n    = head[0];
            stop_n  = head[STOP_BIT];
            busy_n  = 1'b1;
            state_n = S_WAIT;
          end else if (bus_busy) begin
            req_n   = 1'b1;
            op_n    = OP_WRITE;
            byte_n  = head[7:0];
            last_n  = 1'b0;
            rd_n    = 1'b0;
            stop_n  = head[STOP_BIT];
            state_n = S_WAIT;
          end else begin
            set_err = 1'b1;
          end
        end
      end
      S_WAIT: begin
        if (eng_done) begin
          req_n = 1'b0;
          unique case (eng_op)
            OP_START, OP_WRITE: begin
              if (eng_nack) begin
                set_err = 1'b1;
                state_n = S_FLUSH;
              end else if (eng_op == OP_START && rd_q) begin
                state_n = S_LEN;
              end else begin
                state_n = stop_q ? S_STOP : S_IDLE;
              end
            end
            OP_READ: begin
              rxv_n  = 1'b1;
              rxd_n  = eng_rdata;
              left_n = left_q - 1'b1;
              if (left_q == 8'd1) state_n = stop_q ? S_STOP : S_IDLE;
              else                state_n = S_READ;
            end
            default: begin
              busy_n  = 1'b0;
              set_bnb = 1'b1;
              state_n = S_IDLE;
            end
          endcase
        end
      end
      S_LEN: begin
        if (!empty) begin
          pop    = 1'b1;
          left_n = head[7:0];
          stop_n = head[STOP_BIT];
          if (head[7:0] == 8'd0) state_n = head[STOP_BIT] ? S_STOP : S_IDLE;
          else                   state_n = S_READ;
        end
      end
      S_READ: begin
        req_n   = 1'b1;
        op_n    = OP_READ;
        byte_n  = 8'd0;
        last_n  = (left_q == 8'd1);
        state_n = S_WAIT;
      end
      S_FLUSH: begin
        if (empty || head[START_BIT]) state_n = S_STOP;
        else                          pop     = 1'b1;
      end
      default: begin
        req_n   = 1'b1;
        op_n    = OP_STOP;
        byte_n  = 8'd0;
        last_n  = 1'b0;
        state_n = S_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      eng_req  <= 1'b0;
      eng_op   <= OP_START;
      eng_byte <= '0;
      eng_last <= 1'b0;
      bus_busy <= 1'b0;
      stop_q   <= 1'b0;
      rd_q     <= 1'b0;
      left_q   <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      state    <= state_n;
      eng_req  <= req_n;
      eng_op   <= op_n;
      eng_byte <= byte_n;
      eng_last <= last_n;
      bus_busy <= busy_n;
      stop_q   <= stop_n;
      rd_q     <= rd_n;
      left_q   <= left_n;
      rx_valid <= rxv_n;
      rx_data  <= rxd_n;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte) && $stable(eng_last))); // R11
  AST_LAST_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_op != OP_READ) |-> !eng_last); // R5
  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && eng_op == OP_STOP) |=> !bus_busy); // R4
  AST_START_CLAIMS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_op == OP_START) |-> bus_busy); // R2
endmodule

// File: rtl/seqq_irq.sv
module seqq_irq #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          set_err,
  input  logic          set_bnb,
  input  logic [7:0]    clr,
  output logic [7:0]    irq_src
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  logic err_q, bnb_q, err_n, bnb_n;

  always_comb begin
    err_n = set_err || (err_q && !clr[1]);
    bnb_n = set_bnb || (bnb_q && !clr[4]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      bnb_q <= 1'b0;
    end else begin
      err_q <= err_n;
      bnb_q <= bnb_n;
    end
  end

  always_comb begin
    irq_src    = '0;
    irq_src[1] = err_q;
    irq_src[2] = (count == '0);
    irq_src[4] = bnb_q;
    irq_src[7] = (count <= HALF);
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr[1]) |=> err_q); // R10
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output logic [LW-1:0]     fifo_level,
  output logic              fifo_full,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_byte,
  output logic              eng_last,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [7:0]        eng_rdata,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              bus_busy,
  output logic [7:0]        irq_src,
  input  logic [7:0]        irq_clr
);
  logic [WORD_W-1:0] head;
  logic [CW-1:0]     count, count_m1;
  logic              empty, pop, set_err, set_bnb;
  bus_op_e           op;

  seqq_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_word(wr_word), .pop(pop),
    .head(head), .count(count), .full(fifo_full), .empty(empty)
  );

  seqq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .head(head), .empty(empty), .pop(pop),
    .eng_req(eng_req), .eng_op(op), .eng_byte(eng_byte), .eng_last(eng_last),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .bus_busy(bus_busy),
    .set_err(set_err), .set_bnb(set_bnb)
  );

  seqq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .count(count), .set_err(set_err),
    .set_bnb(set_bnb), .clr(irq_clr), .irq_src(irq_src)
  );

  assign eng_op     = op;
  assign count_m1   = empty ? '0 : count - 1'b1;
  assign fifo_level = count_m1[LW-1:0];
endmodule

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_word = '0;
  logic [3:0] fifo_level;
  logic       fifo_full, eng_req, eng_last, rx_valid, bus_busy;
  logic [1:0] eng_op;
  logic [7:0] eng_byte, rx_data, irq_src;
  logic [7:0] irq_clr = '0;
  logic       eng_done, eng_nack;
  logic [7:0] eng_rdata;

  int errors = 0, checks = 0;
  logic eng_en = 1'b0, clr_log = 1'b0;
  int   nack_at = -1;
  int   log_n, rx_n, cnt;
  int   log_v [64];
  logic [7:0] rx_v [64];
  int   exp_n = 0, erx_n = 0;
  int   exp_v [64];
  logic [7:0] erx_v [64];

  i2c_cmd_seq uut (.*);

  always #(CLK_P/2) clk = ~clk;

  // Bit-engine model: answers each request after three cycles, logs it.
  always @(posedge clk) begin
    if (!rst_n || clr_log) begin
      eng_done <= 1'b0; eng_nack <= 1'b0; eng_rdata <= '0;
      log_n <= 0; rx_n <= 0; cnt <= 0;
    end else begin
      if (rx_valid) begin rx_v[rx_n] <= rx_data; rx_n <= rx_n + 1; end
      if (eng_done) begin
        eng_done <= 1'b0; cnt <= 0;
      end else if (eng_req && eng_en) begin
        if (cnt == 2) begin
          eng_done  <= 1'b1;
          eng_nack  <= (log_n == nack_at) && (eng_op < 2'd2);
          eng_rdata <= 8'(log_n) ^ 8'h5A;
          log_v[log_n] <= {22'd0, eng_op, eng_byte, eng_last};
          log_n <= log_n + 1;
          cnt <= 0;
        end else cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] w);
    @(negedge clk); wr_en = 1'b1; wr_word = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic fresh();
    @(negedge clk); clr_log = 1'b1; eng_en = 1'b0;
    @(negedge clk); clr_log = 1'b0;
    exp_n = 0; erx_n = 0;
  endtask

  task automatic ex(input int op, input int b, input int last);
    exp_v[exp_n] = (op << 9) | (b << 1) | last;
    if (op == 2) begin erx_v[erx_n] = 8'(exp_n) ^ 8'h5A; erx_n++; end
    exp_n++;
  endtask

  task automatic run_check(input string req);
    eng_en = 1'b1;
    repeat (200) @(negedge clk);
    chk(log_n == exp_n, req, "op count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk(log_v[i] == exp_v[i], req, $sformatf("op %0d {op,byte,last}", i), log_v[i], exp_v[i]);
    chk(rx_n == erx_n, req, "rx count", rx_n, erx_n);
    for (int i = 0; i < erx_n && i < rx_n; i++)
      chk(rx_v[i] == erx_v[i], req, $sformatf("rx byte %0d", i), rx_v[i], erx_v[i]);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 8'h12;
    @(negedge clk); irq_clr = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: R9, R10
    chk(irq_src == 8'h84, "R9", "reset irq_src", irq_src, 8'h84);
    chk(!bus_busy && !eng_req && fifo_level == 0, "R10", "reset idle", {bus_busy, eng_req, fifo_level}, 0);

    // Fill sweep with a stalled engine: R1, R9, R11, R2, R3, R4
    fresh();
    push(10'h1A0);
    repeat (10) @(negedge clk);
    chk(eng_req && eng_op == 2'd0 && eng_byte == 8'hA0, "R11", "held START", {eng_req, eng_op, eng_byte}, 11'h4A0);
    chk(bus_busy, "R2", "bus claimed", bus_busy, 1);
    for (int k = 1; k <= 16; k++) begin
      push((k == 16) ? 10'(10'h200 | k) : 10'(k));
      chk(fifo_level == 4'(k - 1), "R1", $sformatf("level after %0d", k), fifo_level, k - 1);
      chk(fifo_full == (k == 16), "R1", $sformatf("full after %0d", k), fifo_full, k == 16);
      chk(irq_src[7] == (k <= 8), "R9", $sformatf("half after %0d", k), irq_src[7], k <= 8);
      chk(!irq_src[2], "R9", "not empty", irq_src[2], 0);
    end
    push(10'h0EE);
    chk(fifo_level == 4'd15, "R1", "push when full dropped", fifo_level, 15);
    ex(0, 8'hA0, 0);
    for (int k = 1; k <= 16; k++) ex(1, k, 0);
    ex(3, 0, 0);
    run_check("R3");
    chk(irq_src == 8'h94, "R10", "bus-not-busy after STOP", irq_src, 8'h94);
    chk(!bus_busy, "R4", "bus free", bus_busy, 0);
    clear_irq();
    chk(irq_src == 8'h84, "R10", "clear sticky", irq_src, 8'h84);

    // Address-only write with STOP: R4
    fresh();
    push(10'h384);
    ex(0, 8'h84, 0); ex(3, 0, 0);
    run_check("R4");

    // Read length sweep with STOP: R5, R6
    for (int n = 1; n <= 6; n++) begin
      fresh();
      push(10'h1A1); push(10'(10'h200 | n));
      ex(0, 8'hA1, 0);
      for (int j = 1; j <= n; j++) ex(2, 0, j == n);
      ex(3, 0, 0);
      run_check("R5");
      chk(!bus_busy, "R6", "idle after read stop", bus_busy, 0);
    end

    // Repeated start after a write, then a read: R3, R6
    fresh();
    push(10'h140); push(10'h011); push(10'h141); push(10'h202);
    ex(0, 8'h40, 0); ex(1, 8'h11, 0); ex(0, 8'h41, 0); ex(2, 0, 0); ex(2, 0, 1); ex(3, 0, 0);
    run_check("R6");

    // Read without STOP holds the bus: R6
    fresh();
    push(10'h141); push(10'h001);
    ex(0, 8'h41, 0); ex(2, 0, 1);
    run_check("R6");
    chk(bus_busy, "R6", "bus held after read", bus_busy, 1);
    fresh();
    push(10'h342);
    ex(0, 8'h42, 0); ex(3, 0, 0);
    run_check("R6");

    // NACK on address: R7
    clear_irq();
    fresh();
    nack_at = 0;
    push(10'h190); push(10'h001); push(10'h002); push(10'h392);
    ex(0, 8'h90, 0); ex(3, 0, 0); ex(0, 8'h92, 0); ex(3, 0, 0);
    run_check("R7");
    chk(irq_src[1], "R7", "error flag on address nack", irq_src[1], 1);

    // NACK on a data byte: R7
    clear_irq();
    fresh();
    nack_at = 1;
    push(10'h190); push(10'h001); push(10'h202); push(10'h394);
    ex(0, 8'h90, 0); ex(1, 8'h01, 0); ex(3, 0, 0); ex(0, 8'h94, 0); ex(3, 0, 0);
    run_check("R7");
    chk(irq_src[1], "R7", "error flag on data nack", irq_src[1], 1);
    nack_at = -1;

    // Data word while idle: R8
    clear_irq();
    chk(!irq_src[1], "R10", "error cleared", irq_src[1], 0);
    fresh();
    push(10'h055);
    run_check("R8");
    chk(irq_src[1] && fifo_level == 0 && !bus_busy, "R8", "dropped with error", {irq_src[1], fifo_level, bus_busy}, 6'h20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule